// File: doc/BRIEF.md
# Packed Lane Multimedia Execute Unit

This unit is an execute stage for multimedia work on values held in ordinary 64-bit integer registers. Each register is treated as a set of packed lanes. The unit offers a small set of operations:

- lane-wise maximum and minimum on eight byte lanes or four 16-bit lanes, each in signed or unsigned form;
- a pixel-error operation that sums the absolute differences of eight byte pairs, used for motion search;
- narrowing packs that gather the low byte of wider elements;
- widening unpacks that zero-extend bytes into wider elements.

An operation enters as a 4-bit select and two 64-bit operands, A and B, on a valid/ready stream. The result leaves one cycle later on a second valid/ready stream, together with an error flag.

Back-pressure rules:

- An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high.
- An output beat transfers where `out_valid` and `out_ready` are both high.
- The unit holds a single result register. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so full throughput is one operation per cycle.
- While the consumer stalls, the pending result and its flag stay unchanged and no new input is taken.
- The producer may hold `in_valid` for as long as it likes.

Top module: `pxl_simd_unit`

## Requirements
- R1: Byte lanes. Select codes 0 (max unsigned), 1 (max signed), 4 (min unsigned) and 5 (min signed) compare the eight byte lanes of A and B. Lane i is bits [8i+7:8i]. Each result lane holds the larger or smaller of the two lanes.
- R2: Word lanes. Select codes 2 (max unsigned), 3 (max signed), 6 (min unsigned) and 7 (min signed) do the same on four 16-bit lanes. Lane i is bits [16i+15:16i].
- R3: In max and min operations each lane's result depends only on that lane of A and B. Nothing carries across a lane boundary.
- R4: Select code 8 returns the sum of |A byte i − B byte i| over the eight unsigned byte pairs, zero-extended to 64 bits.
- R5: Select code 9 places the low byte of each 16-bit element of B into result bytes 0..3 in lane order. The upper four bytes are zero and A has no effect.
- R6: Select code 10 places the low byte of each 32-bit element of B into result bytes 0..1. All other bytes are zero and A has no effect.
- R7: Select code 11 zero-extends bytes 0..3 of B into four 16-bit result lanes. A has no effect.
- R8: Select code 12 zero-extends bytes 0..1 of B into two 32-bit result lanes. A has no effect.
- R9: Select codes 13 to 15 produce a zero result with `out_err` high. Every other code produces `out_err` low.
- R10: An input accepted on a rising edge shows as `out_valid` high right after that edge.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_err` hold their values.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation beat offered |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 4 | Operation select |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result |
| out_err | output | 1 | Unsupported select code |

## Verification
The bound checker watches the stream contract on every cycle:

- an accepted beat appears as a valid result on the next cycle;
- a stalled result and its flag stay stable, and the input side is closed during the stall;
- a flagged result is always zero.

The arithmetic of each operation can only be shown by the bench scenarios. These compare every transferred result against a behavioural lane model. They cover signed versus unsigned extremes, equal lanes, isolated lane changes, full-scale and zero pixel error, pack and unpack with random A, and the unsupported codes. All of this runs under random consumer stalls.

// File: rtl/pxl_simd_pkg.sv
package pxl_simd_pkg;
  localparam int OP_W   = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LONG_W = 32;

  typedef enum logic [OP_W-1:0] {
    OP_MAXUB = 4'd0,
    OP_MAXSB = 4'd1,
    OP_MAXUW = 4'd2,
    OP_MAXSW = 4'd3,
    OP_MINUB = 4'd4,
    OP_MINSB = 4'd5,
    OP_MINUW = 4'd6,
    OP_MINSW = 4'd7,
    OP_SAD   = 4'd8,
    OP_PACKW = 4'd9,
    OP_PACKL = 4'd10,
    OP_UNPKW = 4'd11,
    OP_UNPKL = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    PK_W2B = 2'd0,
    PK_L2B = 2'd1,
    UP_B2W = 2'd2,
    UP_B2L = 2'd3
  } pk_mode_e;
endpackage

// File: rtl/pxl_lane_minmax.sv
module pxl_lane_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              take_max,
  output logic [DATA_W-1:0] y
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic              a_gt;
    assign la = a[i*LANE_W +: LANE_W];
    assign lb = b[i*LANE_W +: LANE_W];
    always_comb begin
      if (is_signed) a_gt = $signed(la) > $signed(lb);
      else           a_gt = la > lb;
    end
    assign y[i*LANE_W +: LANE_W] = (a_gt == take_max) ? la : lb;
  end
endmodule

// File: rtl/pxl_sad.sv
module pxl_sad #(
  parameter int DATA_W = 64,
  parameter int ELEM_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int LANES = DATA_W / ELEM_W;
  localparam int SUM_W = ELEM_W + $clog2(LANES);

  logic [ELEM_W-1:0] diff [LANES];
  logic [SUM_W-1:0]  sum;

  for (genvar i = 0; i < LANES; i++) begin : g_diff
    logic [ELEM_W-1:0] ea, eb;
    assign ea = a[i*ELEM_W +: ELEM_W];
    assign eb = b[i*ELEM_W +: ELEM_W];
    assign diff[i] = (ea > eb) ? (ea - eb) : (eb - ea);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + {{(SUM_W-ELEM_W){1'b0}}, diff[i]};
    end
  end

  assign y = {{(DATA_W-SUM_W){1'b0}}, sum};
endmodule

// File: rtl/pxl_pack.sv
module pxl_pack
  import pxl_simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  input  pk_mode_e          mode,
  output logic [DATA_W-1:0] y
);
  localparam int NW = DATA_W / WORD_W;
  localparam int NL = DATA_W / LONG_W;

  logic [DATA_W-1:0] w2b, l2b, b2w, b2l;

  assign w2b[DATA_W-1:NW*BYTE_W] = '0;
  for (genvar i = 0; i < NW; i++) begin : g_w2b
    assign w2b[i*BYTE_W +: BYTE_W] = src[i*WORD_W +: BYTE_W];
    assign b2w[i*WORD_W +: WORD_W] = {{(WORD_W-BYTE_W){1'b0}}, src[i*BYTE_W +: BYTE_W]};
  end

  assign l2b[DATA_W-1:NL*BYTE_W] = '0;
  for (genvar i = 0; i < NL; i++) begin : g_l2b
    assign l2b[i*BYTE_W +: BYTE_W] = src[i*LONG_W +: BYTE_W];
    assign b2l[i*LONG_W +: LONG_W] = {{(LONG_W-BYTE_W){1'b0}}, src[i*BYTE_W +: BYTE_W]};
  end

  always_comb begin
    unique case (mode)
      PK_W2B:  y = w2b;
      PK_L2B:  y = l2b;
      UP_B2W:  y = b2w;
      default: y = b2l;
    endcase
  end
endmodule

// File: rtl/pxl_simd_unit.sv
module pxl_simd_unit
  import pxl_simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  logic [DATA_W-1:0] byte_y, word_y, sad_y, pk_y, res;
  logic              lane_signed, lane_max, bad_op;
  pk_mode_e          pk_mode;

  // Select bit 0 picks signed compare, bit 2 picks minimum.
  assign lane_signed = in_op[0];
  assign lane_max    = ~in_op[2];

  pxl_lane_minmax #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_mm_byte (
    .a(in_a), .b(in_b), .is_signed(lane_signed), .take_max(lane_max), .y(byte_y)
  );

  pxl_lane_minmax #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_mm_word (
    .a(in_a), .b(in_b), .is_signed(lane_signed), .take_max(lane_max), .y(word_y)
  );

  pxl_sad #(.DATA_W(DATA_W), .ELEM_W(BYTE_W)) u_sad (
    .a(in_a), .b(in_b), .y(sad_y)
  );

  always_comb begin
    unique case (in_op)
      OP_PACKW: pk_mode = PK_W2B;
      OP_PACKL: pk_mode = PK_L2B;
      OP_UNPKW: pk_mode = UP_B2W;
      default:  pk_mode = UP_B2L;
    endcase
  end

  pxl_pack #(.DATA_W(DATA_W)) u_pack (
    .src(in_b), .mode(pk_mode), .y(pk_y)
  );

  always_comb begin
    res    = '0;
    bad_op = 1'b0;
    unique case (in_op)
      OP_MAXUB, OP_MAXSB, OP_MINUB, OP_MINSB: res = byte_y;
      OP_MAXUW, OP_MAXSW, OP_MINUW, OP_MINSW: res = word_y;
      OP_SAD:                                 res = sad_y;
      OP_PACKW, OP_PACKL, OP_UNPKW, OP_UNPKL: res = pk_y;
      default:                                bad_op = 1'b1;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        out_data <= res;
        out_err  <= bad_op;
      end
    end
  end
endmodule

// File: rtl/pxl_simd_unit_chk.sv
module pxl_simd_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_err
);
  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  // R11
  stall_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind pxl_simd_unit pxl_simd_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
);

// File: tb/pxl_simd_unit_test.sv
module pxl_simd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  bit stall_mode = 0;
  bit acc_last = 0;
  bit stall_last = 0;
  logic [64:0] held;
  logic [64:0] expq[$];
  string       tagq[$];

  always #2.5 clk = ~clk;

  pxl_simd_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
  );

  function automatic logic [64:0] ref_calc(input logic [3:0] op, input logic [63:0] a, b);
    logic [63:0] r = '0;
    logic e = 1'b0;
    if (op < 4'd8) begin
      int w = op[1] ? 16 : 8;
      logic [63:0] m = (64'd1 << w) - 64'd1;
      for (int i = 0; i < 64 / w; i++) begin
        longint x = longint'((a >> (i*w)) & m);
        longint y = longint'((b >> (i*w)) & m);
        longint p;
        if (op[0]) begin
          if (x >= (longint'(1) << (w-1))) x = x - (longint'(1) << w);
          if (y >= (longint'(1) << (w-1))) y = y - (longint'(1) << w);
        end
        p = op[2] ? ((x < y) ? x : y) : ((x > y) ? x : y);
        r = r | ((64'(p) & m) << (i*w));
      end
    end else begin
      case (op)
        4'd8: for (int i = 0; i < 8; i++) begin
          int x = int'(a[i*8 +: 8]);
          int y = int'(b[i*8 +: 8]);
          r = r + 64'((x > y) ? x - y : y - x);
        end
        4'd9:  for (int i = 0; i < 4; i++) r[i*8 +: 8] = b[i*16 +: 8];
        4'd10: for (int i = 0; i < 2; i++) r[i*8 +: 8] = b[i*32 +: 8];
        4'd11: for (int i = 0; i < 4; i++) r[i*16 +: 16] = {8'h00, b[i*8 +: 8]};
        4'd12: for (int i = 0; i < 2; i++) r[i*32 +: 32] = {24'h0, b[i*8 +: 8]};
        default: e = 1'b1;
      endcase
    end
    return {e, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op < 4'd8) return op[1] ? "R2" : "R1";
    case (op)
      4'd8:    return "R4";
      4'd9:    return "R5";
      4'd10:   return "R6";
      4'd11:   return "R7";
      4'd12:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic observe();
    if (acc_last) begin
      checks++;
      if (!out_valid) begin
        fails++;
        $display("FAIL R10 out_valid=%0b expected 1 after accept", out_valid);
      end
    end
    acc_last = 0;
    if (stall_last) begin
      checks++;
      if ({out_err, out_data} !== held || !out_valid) begin
        fails++;
        $display("FAIL R11 held=%h/%0b expected %h valid 1", {out_err, out_data}, out_valid, held);
      end
    end
    stall_last = out_valid && !out_ready;
    held = {out_err, out_data};
    if (out_valid && out_ready) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected result %h expected none", out_data);
      end else begin
        logic [64:0] ex = expq.pop_front();
        string tg = tagq.pop_front();
        if ({out_err, out_data} !== ex) begin
          fails++;
          $display("FAIL %s got err=%0b data=%h expected err=%0b data=%h",
                   tg, out_err, out_data, ex[64], ex[63:0]);
        end
      end
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [63:0] a, b, input string tg);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_op     = op;
      in_a      = a;
      in_b      = b;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      #1;
      observe();
      if (in_ready) begin
        expq.push_back(ref_calc(op, a, b));
        tagq.push_back(tg);
        acc_last = 1;
        done = 1;
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && (expq.size() != 0 || out_valid); k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      #1;
      observe();
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    // R12 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 valid=%0b ready=%0b expected 0/1", out_valid, in_ready);
    end

    // R1 signed/unsigned byte extremes
    for (int op = 0; op < 8; op += 4)
      for (int s = 0; s < 2; s++)
        send(4'(op + s), 64'h807F00FF0110FE02, 64'h7F80FF00021001FE, "R1");
    // R2 word extremes
    for (int op = 2; op < 8; op += 4)
      for (int s = 0; s < 2; s++)
        send(4'(op + s), 64'h80007FFF0001FFFF, 64'h7FFF8000FFFF0001, "R2");
    // R3 lane isolation: a single lane differs at a boundary
    send(4'd0, 64'h0000000000000000, 64'h00000000000000FF, "R3");
    send(4'd5, 64'h0000000000000100, 64'h00000000000000FF, "R3");
    send(4'd2, 64'h0000FFFF00000000, 64'h0001000000000000, "R3");
    send(4'd7, 64'h8000000000007FFF, 64'h7FFF800000008000, "R3");
    // R4 pixel error corners
    send(4'd8, 64'hFFFFFFFFFFFFFFFF, 64'h0, "R4");
    send(4'd8, 64'h123456789ABCDEF0, 64'h123456789ABCDEF0, "R4");
    send(4'd8, 64'h00FF10EF80017F02, 64'hFF00EF1001800270, "R4");
    // R5..R8 with nonzero A to show A has no effect
    send(4'd9,  64'hDEADBEEFDEADBEEF, 64'h1122334455667788, "R5");
    send(4'd10, 64'hFFFFFFFFFFFFFFFF, 64'h1122334455667788, "R6");
    send(4'd11, 64'hCAFEF00DCAFEF00D, 64'h1122334455667788, "R7");
    send(4'd12, 64'h0123456789ABCDEF, 64'h11223344556677F8, "R8");
    // R9 unsupported codes
    for (int op = 13; op < 16; op++)
      send(4'(op), 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, "R9");
    drain();

    // Random traffic under consumer stalls (R11)
    stall_mode = 1;
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op = 4'($urandom % 16);
      send(op, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(op));
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule